// File: doc/BRIEF.md
# Phase-Correct PWM Generator with Rebuilt Timebase

This block runs a single up/down counter at the full clock rate. The counter climbs from 0 to 255 and then falls back to 0, again and again. It uses that counter both for a symmetric (phase-correct) PWM output and as the system's only free-running clock of time. Each time the counter turns around, at the top and at the bottom, an 8-bit turnaround counter advances. The block then builds a 16-bit timestamp from three things: the turnaround counter as the upper byte, and the raw count corrected for the current direction as the lower byte. Other logic can capture this timestamp at any two events and subtract the two values modulo 2^16 to measure the time between them.

The duty value is captured only while the counter sits at the bottom. A change applied mid-period therefore never chops a pulse. The direction flag and the two turnaround strobes are brought out, so that a consumer can tell which half of the period is running.

Top module: `pwm_timebase`

## Requirements
- R1: A synchronous active-high reset sets the count to 0, the direction flag to 1 (up), the turnaround counter to 0 and the latched duty to 0. While reset is held, the timestamp reads 0, `pwm_o` is low, `at_bottom_o` is high and `at_top_o` is low.
- R2: Out of reset, the count rises by one each clock up to 255, then falls by one each clock down to 0, then rises again. Each value from 1 to 254 is visited twice per 510-clock period, and 0 and 255 once each.
- R3: `up_o` is 1 while the count is rising. It reads 0 from the clock in which the count shows 255 and returns to 1 in the clock in which the count shows 0.
- R4: The turnaround counter (timestamp bits 15:8) increments by one in the clock in which the count arrives at 255 and in the clock in which it arrives at 0 from above. The reset bottom does not count, and the counter wraps from 255 to 0.
- R5: The timestamp low byte equals the count while `up_o` is 1. While `up_o` is 0 it equals (256 − count) mod 256.
- R6: Between consecutive clocks out of reset, the timestamp grows by exactly 1 modulo 2^16. The one exception is the arrival at 255, where it grows by 3.
- R7: `pwm_o` is 1 exactly when the count is less than the latched duty.
- R8: `duty_i` is sampled only at the clock edge that ends a cycle in which the count is 0. Changes at any other time have no effect on `pwm_o` until the next bottom.
- R9: With a latched duty of 0, `pwm_o` never goes high. With a latched duty of 255, it is high in 509 of every 510 clocks, low only while the count is 255.
- R10: `at_top_o` is high exactly when the count is 255, and `at_bottom_o` is high exactly when the count is 0. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| duty_i | input | 8 | Requested compare value, taken at the bottom |
| pwm_o | output | 1 | Phase-correct PWM output |
| stamp_o | output | 16 | Timestamp: turnaround count and corrected low byte |
| count_o | output | 8 | Raw up/down count |
| up_o | output | 1 | 1 while counting up, 0 while counting down |
| at_top_o | output | 1 | High in the cycle the count is 255 |
| at_bottom_o | output | 1 | High in the cycle the count is 0 |

## Verification
The bench goes after the two turnaround clocks, where a design that moved the direction flag or the turnaround counter one cycle early or late would make the timestamp step backwards or jump by 2 or 4 instead of 3. It drives duty changes at random points of the period: a design that latched the duty outside the bottom cycle would show a shortened or stretched pulse that the cycle-level model flags. The extreme duties 0 and 255 are held over whole periods, where an off-by-one compare shows as a stray high or a missing low. The run is long enough for the turnaround counter and the timestamp to wrap, which catches a width or sign slip in the modulo difference.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 8,
  parameter int HW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    duty_i,
  output logic             pwm_o,
  output logic [HW+CW-1:0] stamp_o,
  output logic [CW-1:0]    count_o,
  output logic             up_o,
  output logic             at_top_o,
  output logic             at_bottom_o
);
  localparam int SW = HW + CW;
  localparam logic [CW-1:0] TOP     = {CW{1'b1}};
  localparam logic [CW-1:0] PRE_TOP = TOP - 1'b1;
  localparam logic [CW-1:0] BOT     = '0;
  localparam logic [CW-1:0] PRE_BOT = BOT + 1'b1;

  logic [CW-1:0] cnt_q, duty_q, cnt_nx, low;
  logic [HW-1:0] hi_q;
  logic          up_q, turn_top, turn_bot;

  assign cnt_nx   = up_q ? cnt_q + 1'b1 : cnt_q - 1'b1;
  assign turn_top = up_q && (cnt_nx == TOP);
  assign turn_bot = !up_q && (cnt_nx == BOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= BOT;
      up_q   <= 1'b1;
      hi_q   <= '0;
      duty_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
      if (turn_top)      up_q <= 1'b0;
      else if (turn_bot) up_q <= 1'b1;
      if (turn_top || turn_bot) hi_q <= hi_q + 1'b1;
      if (cnt_q == BOT) duty_q <= duty_i;
    end
  end

  assign low         = up_q ? cnt_q : (~cnt_q) + 1'b1;
  assign stamp_o     = {hi_q, low};
  assign pwm_o       = cnt_q < duty_q;
  assign count_o     = cnt_q;
  assign up_o        = up_q;
  assign at_top_o    = cnt_q == TOP;
  assign at_bottom_o = cnt_q == BOT;

  assert_rise_step_R2: assert property (@(posedge clk) disable iff (rst)
    (up_q && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_fall_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!up_q && cnt_q != BOT) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_flip_at_top_R3: assert property (@(posedge clk) disable iff (rst)
    (up_q && cnt_q == PRE_TOP) |=> (!up_o && at_top_o));

  assert_flip_at_bottom_R3: assert property (@(posedge clk) disable iff (rst)
    (!up_q && cnt_q == PRE_BOT) |=> (up_o && at_bottom_o));

  assert_hi_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (up_q && cnt_q == PRE_TOP) |=> (stamp_o[SW-1:CW] == $past(stamp_o[SW-1:CW]) + 1'b1));

  assert_stamp_step_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((stamp_o - $past(stamp_o)) == SW'(1)) || ((stamp_o - $past(stamp_o)) == SW'(3))));

  assert_duty_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != BOT) |=> $stable(duty_q));

  assert_zero_duty_low_R9: assert property (@(posedge clk) disable iff (rst)
    (duty_q == '0) |-> !pwm_o);

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({at_top_o, at_bottom_o}));
endmodule

// File: tb/pwm_timebase_test.sv
module pwm_timebase_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  duty_i = 8'd0;
  logic        pwm_o, up_o, at_top_o, at_bottom_o;
  logic [15:0] stamp_o;
  logic [7:0]  count_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]  m_cnt, m_duty, m_hi;
  logic        m_up;
  logic [15:0] prev_stamp;
  bit          prev_ok;

  always #10 clk = ~clk;

  pwm_timebase uut (
    .clk(clk), .rst(rst), .duty_i(duty_i), .pwm_o(pwm_o), .stamp_o(stamp_o),
    .count_o(count_o), .up_o(up_o), .at_top_o(at_top_o), .at_bottom_o(at_bottom_o)
  );

  function automatic logic [15:0] exp_stamp(logic [7:0] c, logic u, logic [7:0] h);
    logic [7:0] lo;
    lo = u ? c : 8'(9'd256 - {1'b0, c});
    return {h, lo};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [7:0] n;
    if (rst) begin
      m_cnt = 8'd0; m_up = 1'b1; m_hi = 8'd0; m_duty = 8'd0;
    end else begin
      if (m_cnt == 8'd0) m_duty = duty_i;
      n = m_up ? m_cnt + 8'd1 : m_cnt - 8'd1;
      if (m_up && n == 8'd255)      begin m_up = 1'b0; m_hi = m_hi + 8'd1; end
      else if (!m_up && n == 8'd0)  begin m_up = 1'b1; m_hi = m_hi + 8'd1; end
      m_cnt = n;
    end
  endtask

  task automatic compare_all();
    logic [15:0] d;
    if (rst) begin
      chk("R1 stamp", stamp_o, 0);
      chk("R1 up", up_o, 1);
      chk("R1 pwm", pwm_o, 0);
      chk("R1 bottom", at_bottom_o, 1);
      chk("R1 top", at_top_o, 0);
      prev_ok = 1'b0;
      return;
    end
    chk("R2 count", count_o, m_cnt);
    chk("R3 direction", up_o, m_up);
    chk("R4 high byte", stamp_o[15:8], m_hi);
    chk("R5 stamp", stamp_o, exp_stamp(m_cnt, m_up, m_hi));
    chk("R7 R8 pwm", pwm_o, (m_cnt < m_duty) ? 1 : 0);
    chk("R10 top", at_top_o, (m_cnt == 8'd255) ? 1 : 0);
    chk("R10 bottom", at_bottom_o, (m_cnt == 8'd0) ? 1 : 0);
    if (prev_ok) begin
      d = stamp_o - prev_stamp;
      chk("R6 stamp step", d, (m_cnt == 8'd255 && !m_up) ? 3 : 1);
    end
    prev_stamp = stamp_o;
    prev_ok    = 1'b1;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wait_bottom();
    do cyc(); while (!at_bottom_o);
  endtask

  task automatic count_highs(int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_o) highs++;
      cyc();
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int highs;
    void'($urandom(32'd20240611));
    prev_ok = 1'b0;
    m_cnt = 0; m_up = 1; m_hi = 0; m_duty = 0;
    @(negedge clk);
    duty_i = 8'd90;
    repeat (3) cyc();
    rst = 1'b0;

    // R9: duty 0 over two full periods
    duty_i = 8'd0;
    wait_bottom(); wait_bottom();
    count_highs(1020, highs);
    chk("R9 duty 0 highs", highs, 0);

    // R9: duty 255, start after it has been latched
    duty_i = 8'd255;
    wait_bottom(); wait_bottom();
    count_highs(1020, highs);
    chk("R9 duty 255 highs", highs, 1018);

    // R7: mid duty 128 over one period
    duty_i = 8'd128;
    wait_bottom(); wait_bottom();
    count_highs(510, highs);
    chk("R7 duty 128 highs", highs, 255);

    // R8: raise duty mid-period while latched duty is 0
    duty_i = 8'd0;
    wait_bottom(); wait_bottom();
    repeat (40) cyc();
    duty_i = 8'd255;
    highs = 0;
    while (!at_bottom_o) begin
      if (pwm_o) highs++;
      cyc();
    end
    chk("R8 no effect before bottom", highs, 0);
    cyc();
    chk("R8 takes effect after bottom", pwm_o, 1);

    // random duty changes, long enough for stamp wrap (R4 R6)
    for (int i = 0; i < 70000; i++) begin
      if (($urandom % 64) == 0) duty_i = 8'($urandom);
      cyc();
    end

    // mid-run reset (R1)
    rst = 1'b1;
    cyc(); cyc();
    rst = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (($urandom % 16) == 0) duty_i = 8'($urandom);
      cyc();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule